// File: doc/BRIEF.md
# Priority Process Wakeup Scheduler

This block chooses which of sixteen fixed-priority processes runs on a processor. It keeps three process-indexed sets: the processes that are ready, the processes that are allowed to run (the active set), and the wakeup requests that device controllers or other processes have raised. It also keeps the number of the running process and a nestable counter of reasons for which wakeups are disabled. Requests arrive on a wakeup vector and are ORed into the request set on every clock edge.

At each instruction boundary the block checks whether an active process of higher priority than the running one has a pending request. It makes this check only while the disable counter is zero. If there is one, the block enters its scheduling step. That step moves pending requests of active, not-yet-ready processes into the ready set and selects the highest-priority ready active process. If the selection differs from the running process, the block pulses a switch request. A BLOCK command retires the running process from the ready set and also runs the scheduling step. When nothing is ready, the block sits in an idle loop, repeating the step on every cycle until a request for an active process arrives. The disable counter has increment and decrement commands, and misuse raises trap pulses.

All pins are plain control and status signals. There is no streamed data, so there is no valid/ready handshake and no back-pressure. Commands are single-cycle strobes that take effect on the clock edge that samples them. All outputs are registered.

Top module: `prio_wakeup_sched`

## Requirements
- R1: After reset the disable counter holds 1, the running process is 0, the ready, active and request sets are empty, and switch_o, idle_o and both trap outputs are low.
- R2: inc_i adds 1 and dec_i subtracts 1 from the disable counter. An increment at 255 or a decrement at 0 leaves the counter unchanged and pulses wake_err_o one cycle later. inc_i and dec_i together leave the counter unchanged and raise no trap.
- R3: bnd_i with the counter at zero enters the scheduling step when an active process numbered above the running one has a pending request. If the selection differs, switch_o pulses in the next cycle, with new_pn_o holding the selected process.
- R4: While the counter is nonzero, bnd_i causes no switch. Requests that arrive in that time are kept and are honoured at a later boundary once the counter returns to zero.
- R5: A request for a process numbered below the running one causes no switch at a boundary. It stays pending until the running process blocks.
- R6: blk_i while the counter is nonzero pulses blk_err_o in the next cycle and causes neither a switch nor idling.
- R7: blk_i with the counter at zero removes the running process from the ready set, absorbs pending requests, and switches to the highest-priority ready active process. If that is the running process itself, because its own request was pending, there is no switch.
- R8: When no active process is ready after a scheduling step, idle_o is raised. The block repeats the step every cycle, ignoring bnd_i and blk_i. It leaves idle on the first cycle that finds a ready active process, and pulses switch_o only if that process differs from the last one run.
- R9: A process whose active bit is clear is never selected. Its requests stay pending and are absorbed once its active bit is set by act_we_i/act_wdata_i, which takes effect one cycle after the write.
- R10: A request on wake_i in the same cycle as a scheduling step that absorbs the same process's pending request is kept pending, and not lost.
- R11: In wake_i and act_wdata_i, process p occupies bit 15-p: process 0, the lowest priority, is the most significant bit, and process 15, the highest, is bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bnd_i | input | 1 | Instruction boundary strobe |
| wake_i | input | 16 | Wakeup requests ORed into the request set |
| act_we_i | input | 1 | Write strobe for the active set |
| act_wdata_i | input | 16 | New active set |
| inc_i | input | 1 | Increment the disable counter |
| dec_i | input | 1 | Decrement the disable counter |
| blk_i | input | 1 | BLOCK command from the running process |
| switch_o | output | 1 | One-cycle process switch request |
| new_pn_o | output | 4 | Number of the process selected to run |
| idle_o | output | 1 | No ready active process, idle loop running |
| wake_err_o | output | 1 | One-cycle trap: counter overflow or underflow |
| blk_err_o | output | 1 | One-cycle trap: BLOCK while wakeups are disabled |

## Verification
Two functions can fall in the same cycle: a scheduling step clears a process's absorbed request, and wake_i raises a new request for that same process. The bench provokes this by asserting wake_i for process 9 in the same cycle as the boundary that preempts in favour of process 9. It then has process 9 block. The retained request must re-ready process 9, so the block must report no switch. If the request had been lost, the block would switch down to process 5, and that switch is what the bench reports as a failure.

// File: rtl/sched_pkg.sv
package sched_pkg;
  // Reason the scheduling step runs in the current cycle
  typedef enum logic [1:0] {
    ENT_NONE  = 2'd0,
    ENT_BOUND = 2'd1,
    ENT_BLOCK = 2'd2,
    ENT_IDLE  = 2'd3
  } sched_entry_e;
endpackage

// File: rtl/sched_hp_mask.sv
// Mask of every process that outranks process pn_i (wire bit w holds process N-1-w)
module sched_hp_mask #(
  parameter int N  = 16,
  parameter int PW = 4
) (
  input  logic [PW-1:0] pn_i,
  output logic [N-1:0]  mask_o
);
  localparam int SW = PW + 1;

  for (genvar gw = 0; gw < N; gw++) begin : g_bit
    // process N-1-gw outranks pn  <=>  gw < N-1-pn  <=>  pn + gw < N-1
    assign mask_o[gw] = ({1'b0, pn_i} + SW'(gw)) < SW'(N - 1);
  end
endmodule

// File: rtl/sched_hi_pick.sv
// Highest-numbered process whose bit is set (lowest wire bit wins)
module sched_hi_pick #(
  parameter int N  = 16,
  parameter int PW = 4
) (
  input  logic [N-1:0]  vec_i,
  output logic          found_o,
  output logic [PW-1:0] pn_o
);
  always_comb begin
    found_o = 1'b0;
    pn_o    = '0;
    for (int w = N - 1; w >= 0; w--) begin
      if (vec_i[w]) begin
        found_o = 1'b1;
        pn_o    = PW'(N - 1 - w);
      end
    end
  end
endmodule

// File: rtl/sched_dis_cnt.sv
// Nestable wakeup-disable counter with saturation traps
module sched_dis_cnt #(
  parameter int CW      = 8,
  parameter int RST_VAL = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc_i,
  input  logic dec_i,
  output logic zero_o,
  output logic err_o
);
  localparam logic [CW-1:0] MAXV = '1;

  logic [CW-1:0] cnt_q;
  logic          err_q;
  logic          up_fail, dn_fail;

  assign up_fail = inc_i && !dec_i && (cnt_q == MAXV);
  assign dn_fail = dec_i && !inc_i && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CW'(RST_VAL);
      err_q <= 1'b0;
    end else begin
      err_q <= up_fail || dn_fail;
      if (inc_i && !dec_i && !up_fail)      cnt_q <= cnt_q + 1'b1;
      else if (dec_i && !inc_i && !dn_fail) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero_o = (cnt_q == '0);
  assign err_o  = err_q;

  // R2: a trap leaves the count where it was
  a_r2_trap_holds: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> $stable(cnt_q));
  // R2: no wrap from zero to the top
  a_r2_no_underwrap: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cnt_q) == '0) |-> (cnt_q != MAXV));
  // R2: no wrap from the top to zero
  a_r2_no_overwrap: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cnt_q) == MAXV) |-> (cnt_q != '0));
endmodule

// File: rtl/prio_wakeup_sched.sv
module prio_wakeup_sched
  import sched_pkg::*;
#(
  parameter int NPROC   = 16,
  parameter int CNT_W   = 8,
  parameter int CNT_RST = 1,
  localparam int PW     = $clog2(NPROC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bnd_i,
  input  logic [NPROC-1:0] wake_i,
  input  logic             act_we_i,
  input  logic [NPROC-1:0] act_wdata_i,
  input  logic             inc_i,
  input  logic             dec_i,
  input  logic             blk_i,
  output logic             switch_o,
  output logic [PW-1:0]    new_pn_o,
  output logic             idle_o,
  output logic             wake_err_o,
  output logic             blk_err_o
);
  localparam logic [NPROC-1:0] ONE = NPROC'(1);

  logic [NPROC-1:0] rdy_q, act_q, wreq_q;
  logic [PW-1:0]    cur_q;
  logic             idle_q, sw_q, berr_q;

  logic             woc_zero;
  logic [NPROC-1:0] hp_mask, pend_hi, cur_bit;
  logic [NPROC-1:0] rdy_base, absorb, rdy_nx, wreq_nx;
  logic             found;
  logic [PW-1:0]    sel;
  sched_entry_e     entry;

  sched_dis_cnt #(.CW(CNT_W), .RST_VAL(CNT_RST)) u_dis (
    .clk    (clk),
    .rst_n  (rst_n),
    .inc_i  (inc_i),
    .dec_i  (dec_i),
    .zero_o (woc_zero),
    .err_o  (wake_err_o)
  );

  sched_hp_mask #(.N(NPROC), .PW(PW)) u_mask (
    .pn_i   (cur_q),
    .mask_o (hp_mask)
  );

  assign cur_bit = ONE << (PW'(NPROC - 1) - cur_q);
  assign pend_hi = wreq_q & act_q & hp_mask;

  always_comb begin
    if (idle_q)                                entry = ENT_IDLE;
    else if (blk_i && woc_zero)                entry = ENT_BLOCK;
    else if (bnd_i && woc_zero && |pend_hi)    entry = ENT_BOUND;
    else                                       entry = ENT_NONE;
  end

  always_comb begin
    rdy_base = (entry == ENT_BLOCK) ? (rdy_q & ~cur_bit) : rdy_q;
    absorb   = (entry != ENT_NONE) ? (wreq_q & act_q & ~rdy_base) : '0;
    rdy_nx   = rdy_base | absorb;
    // same-cycle requests land after the absorbed bits are cleared
    wreq_nx  = (wreq_q & ~absorb) | wake_i;
  end

  sched_hi_pick #(.N(NPROC), .PW(PW)) u_pick (
    .vec_i   (rdy_nx & act_q),
    .found_o (found),
    .pn_o    (sel)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q  <= '0;
      act_q  <= '0;
      wreq_q <= '0;
      cur_q  <= '0;
      idle_q <= 1'b0;
      sw_q   <= 1'b0;
      berr_q <= 1'b0;
    end else begin
      rdy_q  <= rdy_nx;
      wreq_q <= wreq_nx;
      berr_q <= blk_i && !woc_zero && !idle_q;
      sw_q   <= 1'b0;
      if (act_we_i) act_q <= act_wdata_i;
      if (entry != ENT_NONE) begin
        if (!found) begin
          idle_q <= 1'b1;
        end else begin
          idle_q <= 1'b0;
          cur_q  <= sel;
          sw_q   <= (sel != cur_q);
        end
      end
    end
  end

  assign switch_o  = sw_q;
  assign new_pn_o  = cur_q;
  assign idle_o    = idle_q;
  assign blk_err_o = berr_q;

  // R8: idling and switching exclude each other
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    idle_o |-> !switch_o);
  // R3: a switch always names a different process
  a_r3_switch_moves: assert property (@(posedge clk) disable iff (!rst_n)
    switch_o |-> (new_pn_o != $past(new_pn_o)));
  // R9: the process switched to was active when chosen
  a_r9_pick_active: assert property (@(posedge clk) disable iff (!rst_n)
    switch_o |-> (($past(act_q) & cur_bit) != '0));
  // R6: the block trap follows a disallowed block only
  a_r6_blk_trap_cause: assert property (@(posedge clk) disable iff (!rst_n)
    blk_err_o |-> ($past(blk_i) && !$past(woc_zero)));
  // R4: a boundary while disabled never switches
  a_r4_boundary_suppressed: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(bnd_i) && !$past(woc_zero) && !$past(idle_q) && !$past(blk_i)) |-> !switch_o);
endmodule

// File: tb/test_prio_wakeup_sched.sv
module test_prio_wakeup_sched;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bnd_i = 1'b0;
  logic [15:0] wake_i = '0;
  logic        act_we_i = 1'b0;
  logic [15:0] act_wdata_i = '0;
  logic        inc_i = 1'b0, dec_i = 1'b0, blk_i = 1'b0;
  logic        switch_o, idle_o, wake_err_o, blk_err_o;
  logic [3:0]  new_pn_o;

  always #5 clk = ~clk;

  prio_wakeup_sched i_prio_wakeup_sched (
    .clk(clk), .rst_n(rst_n), .bnd_i(bnd_i), .wake_i(wake_i),
    .act_we_i(act_we_i), .act_wdata_i(act_wdata_i),
    .inc_i(inc_i), .dec_i(dec_i), .blk_i(blk_i),
    .switch_o(switch_o), .new_pn_o(new_pn_o), .idle_o(idle_o),
    .wake_err_o(wake_err_o), .blk_err_o(blk_err_o)
  );

  typedef struct {
    int         due;
    logic       sw;
    logic [3:0] pn;
    logic       idle;
    logic       we;
    logic       be;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   ncyc = 0;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done = 0;

  always @(posedge clk) ncyc <= ncyc + 1;

  function automatic logic [15:0] pbit(int p);
    return 16'h0001 << (15 - p);
  endfunction

  // driver: one cycle of stimulus plus the outputs expected after its edge
  task automatic cyc(input logic b, input logic [15:0] wk, input logic awe,
                     input logic [15:0] ad, input logic inc, input logic dec,
                     input logic blk, input logic esw, input logic [3:0] epn,
                     input logic eidle, input logic ewe, input logic ebe,
                     input string tag);
    exp_t e;
    @(negedge clk);
    bnd_i = b; wake_i = wk; act_we_i = awe; act_wdata_i = ad;
    inc_i = inc; dec_i = dec; blk_i = blk;
    e.due = ncyc + 1; e.sw = esw; e.pn = epn; e.idle = eidle;
    e.we = ewe; e.be = ebe; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic nop(input logic esw, input logic [3:0] epn, input logic eidle, input string tag);
    cyc(0, '0, 0, '0, 0, 0, 0, esw, epn, eidle, 0, 0, tag);
  endtask

  // monitor: compares every expectation whose edge has passed
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= ncyc) begin
      exp_t e;
      e = q.pop_front();
      n_chk++;
      if ({switch_o, new_pn_o, idle_o, wake_err_o, blk_err_o} !==
          {e.sw, e.pn, e.idle, e.we, e.be}) begin
        n_bad++;
        $display("FAIL %s: sw/pn/idle/werr/berr got %b/%0d/%b/%b/%b expected %b/%0d/%b/%b/%b",
                 e.tag, switch_o, new_pn_o, idle_o, wake_err_o, blk_err_o,
                 e.sw, e.pn, e.idle, e.we, e.be);
      end
    end
  end

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run got stuck, expected completion");
      summary();
    end
  end

  localparam logic [15:0] AP0 = 16'h0000;

  initial begin
    logic [15:0] ap1;
    logic [15:0] ap2;
    ap1 = pbit(2) | pbit(5) | pbit(9);
    ap2 = ap1 | pbit(12);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    nop(0, 0, 0, "R1 reset state");
    cyc(0, '0, 0, AP0, 0, 0, 1, 0, 0, 0, 0, 1, "R6 block while disabled after reset");
    cyc(0, '0, 0, AP0, 0, 1, 0, 0, 0, 0, 0, 0, "R1 R2 decrement from reset value 1");
    cyc(0, '0, 0, AP0, 0, 1, 0, 0, 0, 0, 1, 0, "R2 decrement at zero traps");
    cyc(0, '0, 0, AP0, 1, 1, 0, 0, 0, 0, 0, 0, "R2 inc and dec together");
    cyc(0, '0, 1, ap1, 0, 0, 0, 0, 0, 0, 0, 0, "R9 active set write");
    cyc(0, pbit(5), 0, AP0, 0, 0, 0, 0, 0, 0, 0, 0, "R11 wake process 5");
    cyc(1, '0, 0, AP0, 0, 0, 0, 1, 5, 0, 0, 0, "R3 R11 boundary preempts to 5");
    nop(0, 5, 0, "R3 switch is one pulse");
    cyc(0, pbit(2), 0, AP0, 0, 0, 0, 0, 5, 0, 0, 0, "R5 wake lower process 2");
    cyc(1, '0, 0, AP0, 0, 0, 0, 0, 5, 0, 0, 0, "R5 lower wake does not preempt");
    cyc(0, pbit(12), 0, AP0, 0, 0, 0, 0, 5, 0, 0, 0, "R9 wake inactive 12");
    cyc(1, '0, 0, AP0, 0, 0, 0, 0, 5, 0, 0, 0, "R9 inactive wake does not preempt");
    cyc(0, '0, 0, AP0, 1, 0, 0, 0, 5, 0, 0, 0, "R4 disable wakeups");
    cyc(0, pbit(9), 0, AP0, 0, 0, 0, 0, 5, 0, 0, 0, "R4 wake 9 while disabled");
    cyc(1, '0, 0, AP0, 0, 0, 0, 0, 5, 0, 0, 0, "R4 boundary suppressed");
    cyc(0, '0, 0, AP0, 0, 1, 0, 0, 5, 0, 0, 0, "R4 enable wakeups");
    cyc(1, '0, 0, AP0, 0, 0, 0, 1, 9, 0, 0, 0, "R4 kept wake honoured");
    cyc(0, '0, 0, AP0, 0, 0, 1, 1, 5, 0, 0, 0, "R7 block 9 resumes 5");
    cyc(0, pbit(9), 0, AP0, 0, 0, 0, 0, 5, 0, 0, 0, "R10 wake 9");
    cyc(1, pbit(9), 0, AP0, 0, 0, 0, 1, 9, 0, 0, 0, "R10 absorb with same-cycle wake");
    cyc(0, '0, 0, AP0, 0, 0, 1, 0, 9, 0, 0, 0, "R10 R7 retained wake keeps 9 running");
    cyc(0, '0, 0, AP0, 0, 0, 1, 1, 5, 0, 0, 0, "R7 block 9 again");
    cyc(0, '0, 0, AP0, 0, 0, 1, 1, 2, 0, 0, 0, "R5 R7 pending lower wake runs on block");
    cyc(0, '0, 0, AP0, 0, 0, 1, 0, 2, 1, 0, 0, "R8 nothing ready goes idle");
    cyc(1, '0, 0, AP0, 0, 0, 1, 0, 2, 1, 0, 0, "R8 idle ignores boundary and block");
    cyc(0, '0, 1, ap2, 0, 0, 0, 0, 2, 1, 0, 0, "R9 activate 12 takes a cycle");
    nop(1, 12, 0, "R8 R9 pending 12 absorbed from idle");
    cyc(0, '0, 0, AP0, 0, 0, 1, 0, 12, 1, 0, 0, "R8 block 12 goes idle");
    cyc(0, pbit(2), 0, AP0, 0, 0, 0, 0, 12, 1, 0, 0, "R8 wake during idle");
    nop(1, 2, 0, "R8 leave idle to 2");
    cyc(0, '0, 0, AP0, 0, 0, 1, 0, 2, 1, 0, 0, "R8 block 2 goes idle");
    cyc(0, pbit(2), 0, AP0, 0, 0, 0, 0, 2, 1, 0, 0, "R8 wake same process");
    nop(0, 2, 0, "R8 resume same process without switch");
    cyc(0, '0, 0, AP0, 1, 0, 0, 0, 2, 0, 0, 0, "R6 disable before block");
    cyc(0, '0, 0, AP0, 0, 0, 1, 0, 2, 0, 0, 1, "R6 block while disabled traps");
    for (int i = 2; i <= 255; i++)
      cyc(0, '0, 0, AP0, 1, 0, 0, 0, 2, 0, 0, 0, "R2 increment up to 255");
    cyc(0, '0, 0, AP0, 1, 0, 0, 0, 2, 0, 1, 0, "R2 increment at 255 traps");
    cyc(0, '0, 0, AP0, 1, 1, 0, 0, 2, 0, 0, 0, "R2 inc and dec together at 255");
    for (int i = 0; i < 255; i++)
      cyc(0, '0, 0, AP0, 0, 1, 0, 0, 2, 0, 0, 0, "R2 decrement down to 0");
    cyc(0, '0, 0, AP0, 0, 1, 0, 0, 2, 0, 1, 0, "R2 decrement at 0 traps");
    nop(0, 2, 0, "R2 trap is one pulse");
    repeat (3) @(negedge clk);
    done = 1;
    summary();
  end
endmodule